// File: doc/BRIEF.md
# User-Mode SPI Byte Port

This block gives software a raw path to a serial flash chip. A control word selects the operating mode. While that word selects user mode and its stop-active bit is clear, the block drives chip select low and treats the chip's memory window as a FIFO port. Each bus write shifts its bytes out on MOSI. Each bus read clocks in as many bytes as the access is wide, while MOSI is held high. The address inside the window is ignored. Software can therefore send opcode, address, dummy and data phases as a series of ordinary 1-, 2- or 4-byte accesses and then close the transaction by setting stop-active again.

The bus side uses a request/ready handshake. The master holds `bus_req` and its data steady until `bus_ready` pulses, so the bus stalls for the whole time the bytes are shifting. A sequencer with the states IDLE, LOAD, SHIFT, NEXT and DONE controls each access:

- IDLE→LOAD when a request arrives that may shift.
- IDLE→DONE when a request arrives that may not shift (ignored access).
- LOAD→SHIFT after one byte is handed to the byte shifter.
- SHIFT→NEXT when a byte finishes and more lanes remain.
- SHIFT→DONE when the last lane finishes.
- NEXT→LOAD after the lane index is advanced.
- DONE→IDLE after the one-cycle ready pulse.

The serial link runs in SPI mode 0. SCK idles low and each half period lasts `DIV_HALF` clocks.

Top module: `spi_user_port`

## Requirements
- R1: User mode is active only when `ctrl_word[1:0]` equals 3. In any other mode, accesses complete with no SCK pulse, `spi_cs_n` stays high and reads return zero.
- R2: While `ctrl_word[2]` (stop-active) is 1, `spi_cs_n` is high and accesses produce no SCK pulse. Clearing it in user mode drives `spi_cs_n` low within two clocks. Setting it again drives `spi_cs_n` high within two clocks.
- R3: `bus_size` 0, 1 and 2 transfer 1, 2 and 4 bytes (3 is treated as 4). `bus_addr` has no effect on the bytes or their order.
- R4: The bytes of a multi-byte access travel in ascending lane order: `bus_wdata[7:0]` first, then `[15:8]`, and so on.
- R5: When `wr_gate` is 0, writes complete without any SPI activity. Reads still work.
- R6: A read sends 0xFF on MOSI for every byte. Lane i of `bus_rdata` holds the i-th byte received, and lanes beyond the access size are zero.
- R7: `bus_ready` is a single-cycle pulse. For a shifting access it comes no earlier than 16·`DIV_HALF` clocks per byte after the request, and only after the last bit has been clocked.
- R8: `spi_cs_n` stays low across consecutive accesses until stop-active is set.
- R9: `ctrl_word[5]` selects bit order: 0 sends and receives MSB first, 1 sends and receives LSB first.
- R10: SCK idles low. MISO is sampled on the rising edge, and MOSI is stable at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_word | input | 8 | Control: [1:0] mode, [2] stop-active, [5] LSB first |
| wr_gate | input | 1 | Write-enable gate for user-mode writes |
| bus_req | input | 1 | Access request, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bus_addr | input | 12 | Window offset (ignored) |
| bus_wdata | input | 32 | Write data, lane 0 sent first |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with ready |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach is a chip select held low across several accesses of different widths with no stray clock and no byte slip between them. Reaching it needs the stop-active bit cleared once, then writes of 1, 2 and 4 bytes at unrelated addresses followed by reads, before the bit is set again. The stimulus does exactly this, against a slave model whose MISO stream is a known function of a running byte count. Any byte that is lost or duplicated therefore shifts every later read value. The write gate and the LSB-first bit are then toggled inside that open frame.

// File: rtl/spi_user_pkg.sv
package spi_user_pkg;
    localparam int CTL_STOP_BIT = 2;
    localparam int CTL_LSB_BIT  = 5;
    localparam logic [1:0] MODE_USER = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_NEXT,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/spi_user_tick.sv
module spi_user_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == CW'(DIV_HALF - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == CW'(DIV_HALF - 1));
endmodule

// File: rtl/spi_user_shifter.sv
module spi_user_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx,
    input  logic            lsb_first,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            sck,
    output logic            mosi,
    output logic [BITS-1:0] rx,
    output logic            done
);
    localparam int IW = $clog2(BITS);

    logic            busy_q, phase_q, sck_q, mosi_q, done_q, lsb_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   idx_nx;
    logic [BITS-1:0] tx_q, rx_q;

    function automatic logic [IW-1:0] bitpos(input logic [IW-1:0] i, input logic l);
        return l ? i : (IW'(BITS - 1) - i);
    endfunction

    assign idx_nx = idx_q + IW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b1;
            done_q  <= 1'b0;
            lsb_q   <= 1'b0;
            idx_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                sck_q   <= 1'b0;
                idx_q   <= '0;
                tx_q    <= tx;
                lsb_q   <= lsb_first;
                rx_q    <= '0;
                mosi_q  <= tx[bitpos('0, lsb_first)];
            end else if (busy_q && tick) begin
                if (!phase_q) begin
                    sck_q                     <= 1'b1;
                    rx_q[bitpos(idx_q, lsb_q)] <= miso;
                    phase_q                   <= 1'b1;
                end else begin
                    sck_q   <= 1'b0;
                    phase_q <= 1'b0;
                    if (idx_q == IW'(BITS - 1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        mosi_q <= 1'b1;
                    end else begin
                        idx_q  <= idx_nx;
                        mosi_q <= tx_q[bitpos(idx_nx, lsb_q)];
                    end
                end
            end
        end
    end

    assign busy = busy_q;
    assign sck  = sck_q;
    assign mosi = mosi_q;
    assign rx   = rx_q;
    assign done = done_q;

    // R10: the serial clock never rests high outside a byte
    a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);

    // R7: completion of a byte comes only from a running shift
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q));
endmodule

// File: rtl/spi_user_seq.sv
module spi_user_seq
    import spi_user_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              user_mode,
    input  logic              cs_active,
    input  logic              wr_gate,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int LIW   = (LANES > 1) ? $clog2(LANES) : 1;

    seq_state_e        state_q, state_d;
    logic [LIW-1:0]    idx_q, last_q, last_d;
    logic              write_q, may_shift;
    logic [DATA_W-1:0] rdata_q;

    assign may_shift = user_mode && cs_active && (!bus_write || wr_gate);

    always_comb begin
        unique case (bus_size)
            2'd0:    last_d = LIW'(0);
            2'd1:    last_d = LIW'(1);
            default: last_d = LIW'(LANES - 1);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_req) state_d = may_shift ? ST_LOAD : ST_DONE;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) state_d = (idx_q == last_q) ? ST_DONE : ST_NEXT;
            ST_NEXT:  state_d = ST_LOAD;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // lane bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            last_q  <= '0;
            write_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && bus_req) begin
                idx_q   <= '0;
                last_q  <= last_d;
                write_q <= bus_write;
                rdata_q <= '0;
            end
            if (state_q == ST_SHIFT && sh_done && !write_q) begin
                rdata_q[{idx_q, 3'b000} +: 8] <= sh_rx;
            end
            if (state_q == ST_NEXT) begin
                idx_q <= idx_q + LIW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sh_start  = (state_q == ST_LOAD);
        bus_ready = (state_q == ST_DONE);
        sh_tx     = write_q ? bus_wdata[{idx_q, 3'b000} +: 8] : 8'hFF;
        bus_rdata = rdata_q;
    end

    a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    a_r5_gated_write_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_req && bus_write && !wr_gate) |=> (state_q == ST_DONE));

    a_r1_non_user_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bus_req && !user_mode) |=> (state_q == ST_DONE));

    a_r3_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last_q);
endmodule

// File: rtl/spi_user_port.sv
module spi_user_port
    import spi_user_pkg::*;
#(
    parameter int CTL_W    = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctrl_word,
    input  logic              wr_gate,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic       user_mode, cs_active_q, lsb_first;
    logic       sh_start, sh_done, sh_busy, tick;
    logic [7:0] sh_tx, sh_rx;
    logic       unused_inputs;

    assign user_mode = (ctrl_word[1:0] == MODE_USER);
    assign lsb_first = ctrl_word[CTL_LSB_BIT];
    assign unused_inputs = ^{bus_addr, ctrl_word[CTL_W-1:CTL_LSB_BIT+1],
                             ctrl_word[CTL_LSB_BIT-1:CTL_STOP_BIT+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_active_q <= 1'b0;
        else        cs_active_q <= user_mode && !ctrl_word[CTL_STOP_BIT];
    end

    assign spi_cs_n = !cs_active_q;

    spi_user_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .user_mode (user_mode),
        .cs_active (cs_active_q),
        .wr_gate   (wr_gate),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    spi_user_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .tick  (tick)
    );

    spi_user_shifter #(.BITS(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx        (sh_tx),
        .lsb_first (lsb_first),
        .tick      (tick),
        .miso      (spi_miso),
        .busy      (sh_busy),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .rx        (sh_rx),
        .done      (sh_done)
    );

    // R2: a serial clock edge appears only inside an open frame
    a_r2_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> !spi_cs_n);
endmodule

// File: tb/spi_user_port_tb.sv
module spi_user_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl_word = 8'h00;
    logic        wr_gate = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_checks = 0;
    int n_fail   = 0;
    int rcnt     = 0;
    int exp_bytes = 0;
    int cs_rise  = 0;
    bit bench_lsb = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_byte = '0;
    logic [7:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_user_port #(.DIV_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .wr_gate(wr_gate),
        .bus_req(bus_req), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp_of(input int n);
        return 8'((n * 37 + 90) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // slave model: MISO stream is a function of the running bit count
    always_comb begin
        rb = resp_of(rcnt >> 3);
        spi_miso = bench_lsb ? rb[rcnt[2:0]] : rb[3'd7 - rcnt[2:0]];
    end

    always @(posedge spi_cs_n) cs_rise++;

    // monitor: assembles MOSI bytes and pops the scoreboard
    always @(posedge spi_sck) begin
        automatic int k = rcnt % 8;
        chk(!spi_cs_n, "R2 clock edge with CS inactive", {31'd0, spi_cs_n}, 32'd0);
        mon_byte[bench_lsb ? k : 7 - k] = spi_mosi;
        rcnt = rcnt + 1;
        if (k == 7) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1/R5 unexpected SPI byte", {24'd0, mon_byte}, 32'd0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                chk(mon_byte == e, "R4/R6/R9 MOSI byte", {24'd0, mon_byte}, {24'd0, e});
            end
        end
    end

    task automatic set_ctrl(input logic [1:0] mode, input bit stop, input bit lsb);
        @(negedge clk);
        ctrl_word = {2'b00, lsb, 2'b00, stop, mode};
        bench_lsb = lsb;
        repeat (2) @(negedge clk);
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input logic [11:0] addr,
                          input logic [31:0] wd, input string req);
        automatic int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        automatic bit shifts = (ctrl_word[1:0] == 2'd3) && !ctrl_word[2] && (!wr || wr_gate);
        automatic logic [31:0] exp_rd = '0;
        automatic int cyc = 0;
        if (shifts) begin
            for (int i = 0; i < nb; i++) begin
                exp_q.push_back(wr ? wd[8*i +: 8] : 8'hFF);
                if (!wr) exp_rd[8*i +: 8] = resp_of(exp_bytes + i);
            end
            exp_bytes += nb;
        end
        @(negedge clk);
        bus_req = 1'b1; bus_write = wr; bus_size = sz; bus_addr = addr; bus_wdata = wd;
        forever begin
            @(negedge clk);
            cyc++;
            if (bus_ready || cyc > 3000) break;
        end
        chk(bus_ready, {req, " R7 ready seen"}, {31'd0, bus_ready}, 32'd1);
        if (!wr) chk(bus_rdata == exp_rd, {req, " R6 read data"}, bus_rdata, exp_rd);
        if (shifts)
            chk(cyc >= nb * 16 * HALF, {req, " R7 stall length"}, 32'(cyc), 32'(nb * 16 * HALF));
        chk(exp_q.size() == 0, {req, " R7 all bytes out before ready"}, 32'(exp_q.size()), 32'd0);
        bus_req = 1'b0;
        @(negedge clk);
        chk(!bus_ready, {req, " R7 ready single pulse"}, {31'd0, bus_ready}, 32'd0);
        chk(!spi_sck, {req, " R10 SCK idle low"}, {31'd0, spi_sck}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sck && spi_mosi && !bus_ready, "R2 R10 reset state",
            {28'd0, spi_cs_n, spi_sck, spi_mosi, bus_ready}, 32'b1010);
        rst_n = 1'b1;

        // R1: normal mode, nothing reaches the wire
        set_ctrl(2'd0, 1'b0, 1'b0);
        chk(spi_cs_n, "R1 CS high outside user mode", {31'd0, spi_cs_n}, 32'd1);
        access(1'b1, 2'd2, 12'h000, 32'h11223344, "R1 write");
        access(1'b0, 2'd2, 12'h000, 32'h0, "R1 read zero");

        // R2: user mode but stop-active held
        set_ctrl(2'd3, 1'b1, 1'b0);
        chk(spi_cs_n, "R2 CS high while stop-active", {31'd0, spi_cs_n}, 32'd1);
        access(1'b1, 2'd0, 12'h000, 32'h000000AA, "R2 write ignored");

        set_ctrl(2'd3, 1'b0, 1'b0);
        chk(!spi_cs_n, "R2 CS asserted", {31'd0, spi_cs_n}, 32'd0);
        cs_rise = 0;
        access(1'b1, 2'd0, 12'h010, 32'h0000009F, "R3 one byte");
        access(1'b1, 2'd1, 12'h022, 32'h00001234, "R4 half lanes");
        access(1'b1, 2'd2, 12'hFFC, 32'hDEADBEEF, "R4 word lanes");
        access(1'b1, 2'd3, 12'h7A4, 32'h01020304, "R3 size 3 as word");
        access(1'b0, 2'd2, 12'h100, 32'h0, "R6 word read");
        access(1'b0, 2'd0, 12'h3FF, 32'h0, "R6 byte read");
        access(1'b0, 2'd1, 12'h002, 32'h0, "R6 half read");
        chk(cs_rise == 0, "R8 CS held across accesses", 32'(cs_rise), 32'd0);
        chk(!spi_cs_n, "R8 CS still low", {31'd0, spi_cs_n}, 32'd0);

        // R5: write gate closed inside an open frame
        @(negedge clk); wr_gate = 1'b0;
        access(1'b1, 2'd2, 12'h000, 32'hCAFEF00D, "R5 gated write");
        access(1'b0, 2'd1, 12'h000, 32'h0, "R5 read while gated");
        @(negedge clk); wr_gate = 1'b1;

        // R9: LSB-first ordering in both directions
        set_ctrl(2'd3, 1'b0, 1'b1);
        access(1'b1, 2'd0, 12'h000, 32'h00000001, "R9 lsb write");
        access(1'b1, 2'd1, 12'h000, 32'h0000C380, "R9 lsb half write");
        access(1'b0, 2'd1, 12'h000, 32'h0, "R9 lsb read");

        set_ctrl(2'd3, 1'b1, 1'b0);
        chk(spi_cs_n, "R2 CS released by stop-active", {31'd0, spi_cs_n}, 32'd1);
        chk(rcnt == exp_bytes * 8, "R3 total clock count", 32'(rcnt), 32'(exp_bytes * 8));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule